// File: doc/BRIEF.md
# Table-Based Reciprocal and Inverse Square Root Unit

This unit takes a 32-bit signed operand and returns a 32-bit fixed-point approximation of its reciprocal or of its inverse square root. Two select inputs control it. One picks the function: reciprocal or inverse square root. The other picks how a negative operand is turned into a magnitude: the single or the double precision rule.

The unit normalizes the magnitude with a leading-zero count. From the normalized value and the count it builds a 10-bit index into a 1024-entry table of 16-bit values. The table is computed at elaboration time. The table output, with an implicit leading one, is shifted right by an amount derived from the normalization count. Last, the sign and two saturation cases are applied.

Each accepted operand produces its result one clock later. A valid flag is registered alongside the result.

Top module: `recip_rsqrt_unit`

## Requirements
- R1: With `in_double`=0, the magnitude of a negative operand is its two's-complement negation (so 0x80000000 stays 0x80000000); a non-negative operand is its own magnitude.
- R2: With `in_double`=1, a negative operand of -32768 or greater is negated, and an operand below -32768 is bitwise inverted.
- R3: The shift count `lz` is the number of leading zeros of the 32-bit magnitude; for a zero magnitude it is 16 when `in_double`=0 and 0 when `in_double`=1.
- R4: In reciprocal mode (`in_sqrt`=0) the index is {1'b0, N[30:22]}, where N is the magnitude shifted left by `lz`. Table entry i for i<512 is min(0xFFFF, floor(2^26/(512+i)) - 65536); entry 0 is 0xFFFF.
- R5: In inverse square root mode (`in_sqrt`=1) the index is {1'b1, N[30:23], lz[0]}. Entry 512+2k+p is min(0xFFFF, isqrt(floor(2^(41+p)/(256+k))) - 65536), where isqrt is the integer floor square root; entries 512 and 513 are 0x6A09 and 0xFFFF.
- R6: The right-shift amount is (lz XOR 31), halved (shifted right by one) in inverse square root mode. The raw result is (0x40000000 OR entry<<14) logically shifted right by that amount.
- R7: An operand of zero gives 0x7FFFFFFF in every mode.
- R8: An operand of 0xFFFF8000 (-32768) gives 0xFFFF0000 in every mode.
- R9: Any other negative operand gives the bitwise inverse of the raw result; a positive operand gives the raw result unchanged.
- R10: `out_valid` equals `in_valid` delayed by one clock. `out_result` is loaded with the result of the operand presented in the cycle where `in_valid`=1, and it holds its value while `in_valid`=0.
- R11: While `rst_n` is low, `out_valid` and `out_result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand and selects are valid this cycle |
| in_operand | input | 32 | Signed operand |
| in_sqrt | input | 1 | 1 = inverse square root, 0 = reciprocal |
| in_double | input | 1 | 1 = double precision magnitude rule, 0 = single |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 32 | Fixed-point result |

## Verification
The bench drives zero and -32768 in both function modes and both precisions. A unit that skipped either override would return a table-derived value, or an inverted one, in place of the saturated constant. Operands just below and just above -32768 are sent in double precision, where negating instead of inverting moves the magnitude by one and can change the index or the shift. A unit with a wrong parity bit, or a wrong halving of the shift, fails on the one-and-two operand pair in square-root mode: the expected results there are 0x7FFFC000 and 0x5A824000. The bench also inserts idle cycles between operands. A result register that did not hold, or a valid flag that did not follow its input, shows up on those idle cycles.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

    localparam int DATA_W  = 32;
    localparam int ENTRY_W = 16;
    localparam int IDX_W   = 10;
    localparam int DEPTH   = 1 << IDX_W;
    localparam int HALF    = DEPTH / 2;
    localparam int LZ_W    = $clog2(DATA_W);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
    } out_state_t;

    function automatic longint unsigned int_sqrt(input longint unsigned x);
        longint unsigned r;
        longint unsigned t;
        r = 0;
        for (int b = 20; b >= 0; b--) begin
            t = r | (64'd1 << b);
            if (t * t <= x) r = t;
        end
        return r;
    endfunction

    function automatic logic [ENTRY_W-1:0] tbl_entry(input int idx);
        longint unsigned v;
        longint unsigned k;
        if (idx < HALF) begin
            v = (64'd1 << 26) / longint'(HALF + idx);
        end else begin
            k = longint'((idx - HALF) >> 1);
            if ((idx & 1) != 0) v = int_sqrt((64'd1 << 42) / (64'd256 + k));
            else                v = int_sqrt((64'd1 << 41) / (64'd256 + k));
        end
        v = v - 64'd65536;
        if (v > 64'd65535) v = 64'd65535;
        return v[ENTRY_W-1:0];
    endfunction

endpackage

// File: rtl/rcp_norm.sv
module rcp_norm
    import rcp_pkg::*;
(
    input  logic [DATA_W-1:0] operand,
    input  logic              sqrt_mode,
    input  logic              dbl_mode,
    output logic [IDX_W-1:0]  index,
    output logic [LZ_W-1:0]   lz
);
    logic [DATA_W-1:0] mag;
    logic [DATA_W-1:0] norm;
    logic              found;
    logic              unused_bits;

    always_comb begin
        if (!operand[DATA_W-1]) begin
            mag = operand;
        end else if (!dbl_mode) begin
            mag = -operand;
        end else if ($signed(operand) >= -32'sd32768) begin
            mag = -operand;
        end else begin
            mag = ~operand;
        end
    end

    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (!found && mag[i]) begin
                lz    = LZ_W'(DATA_W - 1 - i);
                found = 1'b1;
            end
        end
        if (!found) lz = dbl_mode ? LZ_W'(0) : LZ_W'(16);
        norm = mag << lz;
    end

    always_comb begin
        if (sqrt_mode) index = {1'b1, norm[30:23], lz[0]};
        else           index = {1'b0, norm[30:22]};
    end

    assign unused_bits = ^{norm[31], norm[21:0]};
endmodule

// File: rtl/rcp_rom.sv
module rcp_rom
    import rcp_pkg::*;
(
    input  logic [IDX_W-1:0]   index,
    output logic [ENTRY_W-1:0] entry
);
    logic [ENTRY_W-1:0] table_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam logic [ENTRY_W-1:0] VAL = tbl_entry(g);
        assign table_q[g] = VAL;
    end

    assign entry = table_q[index];
endmodule

// File: rtl/rcp_scale.sv
module rcp_scale
    import rcp_pkg::*;
(
    input  logic [DATA_W-1:0]  operand,
    input  logic               sqrt_mode,
    input  logic [LZ_W-1:0]    lz,
    input  logic [ENTRY_W-1:0] entry,
    output logic [DATA_W-1:0]  result
);
    localparam logic [DATA_W-1:0] SAT_ZERO   = 32'h7FFF_FFFF;
    localparam logic [DATA_W-1:0] SAT_MINNEG = 32'hFFFF_0000;
    localparam logic [DATA_W-1:0] MIN_HALF   = 32'hFFFF_8000;

    logic [LZ_W-1:0]   rsh;
    logic [DATA_W-1:0] raw;

    always_comb begin
        rsh = lz ^ LZ_W'(DATA_W - 1);
        if (sqrt_mode) rsh = rsh >> 1;
        raw = {2'b01, entry, 14'b0} >> rsh;
        if (operand == '0)               result = SAT_ZERO;
        else if (operand == MIN_HALF)    result = SAT_MINNEG;
        else if (operand[DATA_W-1])      result = ~raw;
        else                             result = raw;
    end
endmodule

// File: rtl/recip_rsqrt_unit.sv
module recip_rsqrt_unit
    import rcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_operand,
    input  logic              in_sqrt,
    input  logic              in_double,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    logic [IDX_W-1:0]   index;
    logic [LZ_W-1:0]    lz;
    logic [ENTRY_W-1:0] entry;
    logic [DATA_W-1:0]  result;
    out_state_t         st_d;
    out_state_t         st_q;

    rcp_norm u_norm (
        .operand   (in_operand),
        .sqrt_mode (in_sqrt),
        .dbl_mode  (in_double),
        .index     (index),
        .lz        (lz)
    );

    rcp_rom u_rom (
        .index (index),
        .entry (entry)
    );

    rcp_scale u_scale (
        .operand   (in_operand),
        .sqrt_mode (in_sqrt),
        .lz        (lz),
        .entry     (entry),
        .result    (result)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) st_d.result = result;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;
endmodule

// File: rtl/recip_rsqrt_unit_chk.sv
module recip_rsqrt_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_operand,
    input logic        out_valid,
    input logic [31:0] out_result
);
    p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));
    p_zero_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_operand == 32'h0) |=> out_result == 32'h7FFF_FFFF);
    p_minneg_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_operand == 32'hFFFF_8000) |=> out_result == 32'hFFFF_0000);
    p_neg_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_operand[31] && in_operand != 32'hFFFF_8000) |=> out_result[31]);
    p_pos_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_operand[31] && in_operand != 32'h0) |=> !out_result[31]);
endmodule

bind recip_rsqrt_unit recip_rsqrt_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_operand (in_operand),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/tb_recip_rsqrt_unit.sv
`timescale 1ns/1ps
module tb_recip_rsqrt_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_operand = '0;
    logic        in_sqrt = 1'b0;
    logic        in_double = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;
    int          total = 0;
    int          bad = 0;
    logic [31:0] last_res;

    always #2.5 clk = ~clk;

    recip_rsqrt_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .in_sqrt(in_sqrt), .in_double(in_double),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic longint unsigned tb_isqrt(input longint unsigned x);
        longint unsigned lo = 0;
        longint unsigned hi = 64'd1 << 18;
        longint unsigned mid;
        while (lo < hi) begin
            mid = (lo + hi + 1) / 2;
            if (mid * mid <= x) lo = mid; else hi = mid - 1;
        end
        return lo;
    endfunction

    function automatic logic [15:0] tb_entry(input int idx);
        longint unsigned v;
        int k;
        if (idx < 512) v = 64'h400_0000 / longint'(512 + idx);
        else begin
            k = (idx - 512) / 2;
            v = tb_isqrt((64'd1 << (41 + (idx % 2))) / longint'(256 + k));
        end
        v = v - 65536;
        if (v > 65535) v = 65535;
        return v[15:0];
    endfunction

    function automatic logic [31:0] ref_model(input logic [31:0] op, input logic sq, input logic dp);
        logic [31:0] mag, n, raw;
        int lz, idx, sh;
        if (op == 32'h0) return 32'h7FFF_FFFF;
        if (op == 32'hFFFF_8000) return 32'hFFFF_0000;
        if (!op[31]) mag = op;
        else if (!dp || $signed(op) >= -32768) mag = 32'h0 - op;
        else mag = ~op;
        lz = 0;
        while (lz < 32 && mag[31 - lz] == 1'b0) lz++;
        if (lz == 32) lz = dp ? 0 : 16;
        n = mag << lz;
        if (sq) idx = 512 + int'(n[30:23]) * 2 + (lz % 2);
        else    idx = int'(n[30:22]);
        sh = 31 - lz;
        if (sq) sh = sh / 2;
        raw = ({2'b01, tb_entry(idx), 14'b0}) >> sh;
        return op[31] ? ~raw : raw;
    endfunction

    function automatic string tag_of(input logic [31:0] op, input logic sq, input logic dp);
        if (op == 0) return "R7";
        if (op == 32'hFFFF_8000) return "R8";
        if (op[31] && dp) return "R2 R9";
        if (op[31]) return "R1 R9";
        if (sq) return "R5 R3 R6";
        return "R4 R3 R6";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] op, input logic sq, input logic dp);
        logic [31:0] e;
        @(negedge clk);
        in_valid = 1'b1; in_operand = op; in_sqrt = sq; in_double = dp;
        e = ref_model(op, sq, dp);
        @(negedge clk);
        check("R10 valid", {31'b0, out_valid}, 32'd1);
        check(tag_of(op, sq, dp), out_result, e);
        last_res = out_result;
        in_valid = 1'b0; in_operand = $urandom; in_sqrt = ~sq;
        @(negedge clk);
        check("R10 idle", {31'b0, out_valid}, 32'd0);
        check("R10 hold", out_result, last_res);
    endtask

    task automatic run_known(input logic [31:0] op, input logic sq, input logic [31:0] e, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_operand = op; in_sqrt = sq; in_double = 1'b0;
        @(negedge clk);
        check(tag, out_result, e);
        in_valid = 1'b0;
    endtask

    initial begin
        #20000000;
        bad++; total++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        #1;
        check("R11 valid", {31'b0, out_valid}, 32'd0);
        check("R11 result", out_result, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_known(32'd1, 1'b0, 32'h7FFF_C000, "R4");
        run_known(32'd1, 1'b1, 32'h7FFF_C000, "R5");
        run_known(32'd2, 1'b1, 32'h5A82_4000, "R5");
        run_known(32'd2, 1'b0, 32'h3FFF_E000, "R6");
        for (int m = 0; m < 4; m++) begin
            run_op(32'h0, m[0], m[1]);
            run_op(32'hFFFF_8000, m[0], m[1]);
            run_op(32'hFFFF_7FFF, m[0], m[1]);
            run_op(32'hFFFF_8001, m[0], m[1]);
            run_op(32'h8000_0000, m[0], m[1]);
            run_op(32'h7FFF_FFFF, m[0], m[1]);
            run_op(32'hFFFF_FFFF, m[0], m[1]);
            run_op(32'h0000_8000, m[0], m[1]);
        end
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            case (i % 3)
                0: run_op(r, r[0], r[1]);
                1: run_op({{16{r[15]}}, r[15:0]}, r[16], r[17]);
                default: run_op(32'hFFFF_8000 + {{24{r[7]}}, r[7:0]}, r[16], r[17]);
            endcase
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule